// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable integer ratio. It stands in for the feedback divider of a frequency synthesizer. A small prescaler counts input clocks and divides by either P+1 or P. Its terminal pulses drive two slower counters. The swallow counter keeps the prescaler in the P+1 mode for its first A output pulses. After that the prescaler drops to the P mode. When the program counter has seen B prescaler pulses, the division cycle ends and a new one starts. The result is a ratio of P·B+A input clocks per output pulse, with only the prescaler needing to run at the full input rate.

Software or a channel-select controller drives the three ratio inputs as plain levels. There is no streaming data and no handshake. The divider samples the ratio inputs only on the last clock of a division cycle, so a ratio change never produces a cycle of a mixed length. A sticky error flag reports a rejected ratio. A rejected ratio leaves the previous one in force.

Top module: `pswallow_divider`

## Requirements
- R1: After a synchronous reset the block is in the following state. `div_out` is 0, `mod_ctl` is 1 (the P+1 mode, since the default A is 1), `cfg_err` is 0, and the active ratio is the default P=4, A=1, B=3.
- R2: Consecutive `div_out` pulses are exactly P·B+A input clocks apart, using the active P, A and B.
- R3: `div_out` is high for exactly one input clock, which is the last clock of each division cycle. The first pulse after reset release falls on clock P·B+A, counting the first clock after release as clock 1.
- R4: `mod_ctl` is 1 (the P+1 mode) for the first (P+1)·A clocks of each cycle and 0 (the P mode) for the remaining P·(B−A) clocks.
- R5: The block samples `cfg_p`, `cfg_a` and `cfg_b` only on a clock where `div_out` is 1. The new ratio governs the next cycle. Changes on any other clock have no effect on the cycle in progress.
- R6: A sampled ratio is valid only if P ≥ 2, B ≥ 1, A < P and A ≤ B. An invalid ratio is not applied: the previous ratio continues and `cfg_err` goes to 1.
- R7: `cfg_err` stays 1 until reset, even after a later valid ratio has been applied.
- R8: With A = 0, `mod_ctl` is 0 for the whole cycle and the cycle lasts P·B clocks.
- R9: With A = B, `mod_ctl` is 1 for the whole cycle and the cycle lasts (P+1)·B clocks.
- R10: A reset asserted in the middle of a cycle abandons that cycle. The block restores the default ratio and clears `cfg_err`, and the next pulse follows the R3 timing from release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (oscillator stand-in) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_p | input | PW | Requested prescaler base modulus P |
| cfg_a | input | PW | Requested swallow count A |
| cfg_b | input | BW | Requested program count B |
| div_out | output | 1 | One-clock pulse on the last clock of each division cycle |
| mod_ctl | output | 1 | Prescaler modulus select: 1 = P+1, 0 = P |
| cfg_err | output | 1 | Sticky flag: a rejected ratio was sampled |

## Verification
A wrong internal state shows at the ports as a shift in the edges. A miscounting prescaler moves the next `div_out` pulse by one or more clocks within a single cycle. A swallow counter off by one moves the falling edge of `mod_ctl` by P+1 clocks in the first cycle where it matters. The bench runs a behavioural count of input clocks against the active ratio and compares both outputs and the error flag on every clock. Any drift is therefore caught on the first clock where an edge lands in the wrong place, at most one division cycle after the fault.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {MODE_P = 1'b0, MODE_P1 = 1'b1} psd_mode_e;

  // ratio legality: base modulus at least 2, at least one program pulse,
  // swallow count below the base modulus and not above the program count
  function automatic logic ratio_ok(input int unsigned p,
                                    input int unsigned a,
                                    input int unsigned b);
    return (p >= 2) && (b >= 1) && (a < p) && (a <= b);
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  psd_mode_e     mode,
  input  logic [PW-1:0] p,
  output logic          tc
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] term;

  // P+1 mode counts 0..P, P mode counts 0..P-1
  assign term = (mode == MODE_P1) ? p : p - 1'b1;
  assign tc   = (cnt == term);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (tc)  cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R2: the fast counter never runs past the largest modulus
  p_pc_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= p);
endmodule

// File: rtl/psd_counters.sv
module psd_counters
  import psd_pkg::*;
#(
  parameter int PW = 4,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tc,
  input  logic [PW-1:0] a,
  input  logic [BW-1:0] b,
  output psd_mode_e     mode,
  output logic          last
);
  logic [PW-1:0] swl_cnt;
  logic [BW-1:0] prg_cnt;

  assign mode = (swl_cnt < a) ? MODE_P1 : MODE_P;
  assign last = tc && (prg_cnt == b - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      swl_cnt <= '0;
      prg_cnt <= '0;
    end else if (tc) begin
      if (last) begin
        swl_cnt <= '0;
        prg_cnt <= '0;
      end else begin
        prg_cnt <= prg_cnt + 1'b1;
        if (swl_cnt < a) swl_cnt <= swl_cnt + 1'b1;
      end
    end
  end

  // R4: the swallow counter saturates at A
  p_swallow_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    swl_cnt <= a);
  // R2: the program counter wraps before reaching B
  p_prog_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    prg_cnt < b);
endmodule

// File: rtl/psd_config.sv
module psd_config
  import psd_pkg::*;
#(
  parameter int PW    = 4,
  parameter int BW    = 6,
  parameter int DEF_P = 4,
  parameter int DEF_A = 1,
  parameter int DEF_B = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] in_p,
  input  logic [PW-1:0] in_a,
  input  logic [BW-1:0] in_b,
  output logic [PW-1:0] p_q,
  output logic [PW-1:0] a_q,
  output logic [BW-1:0] b_q,
  output logic          err
);
  logic ok;
  assign ok = ratio_ok(32'(in_p), 32'(in_a), 32'(in_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= PW'(DEF_P);
      a_q <= PW'(DEF_A);
      b_q <= BW'(DEF_B);
      err <= 1'b0;
    end else if (load) begin
      if (ok) begin
        p_q <= in_p;
        a_q <= in_a;
        b_q <= in_b;
      end else begin
        err <= 1'b1;
      end
    end
  end

  // R5: the active ratio only moves at a cycle boundary
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(p_q) && $stable(a_q) && $stable(b_q)));
  // R7: the error flag never clears outside reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import psd_pkg::*;
#(
  parameter int PW    = 4,
  parameter int BW    = 6,
  parameter int DEF_P = 4,
  parameter int DEF_A = 1,
  parameter int DEF_B = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] cfg_p,
  input  logic [PW-1:0] cfg_a,
  input  logic [BW-1:0] cfg_b,
  output logic          div_out,
  output logic          mod_ctl,
  output logic          cfg_err
);
  logic [PW-1:0] p_q;
  logic [PW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic          tc;
  logic          last;
  psd_mode_e     mode;

  psd_config #(
    .PW(PW), .BW(BW), .DEF_P(DEF_P), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(last),
    .in_p(cfg_p), .in_a(cfg_a), .in_b(cfg_b),
    .p_q(p_q), .a_q(a_q), .b_q(b_q), .err(cfg_err)
  );

  psd_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .mode(mode), .p(p_q), .tc(tc)
  );

  psd_counters #(.PW(PW), .BW(BW)) u_cnt (
    .clk(clk), .rst(rst), .tc(tc), .a(a_q), .b(b_q),
    .mode(mode), .last(last)
  );

  assign div_out = last;
  assign mod_ctl = (mode == MODE_P1);

  // R3: the divided output is never wider than one input clock
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);
endmodule

// File: tb/tb_pswallow_divider.sv
module tb_pswallow_divider;
  localparam int PW = 4;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] cfg_p = 4'd4;
  logic [PW-1:0] cfg_a = 4'd1;
  logic [BW-1:0] cfg_b = 6'd3;
  logic          div_out, mod_ctl, cfg_err;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    started = 0;
  bit    finished = 0;
  string phase = "R1";

  int m_cnt, m_p, m_a, m_b;
  bit m_err;

  pswallow_divider dut (
    .clk(clk), .rst(rst), .cfg_p(cfg_p), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .div_out(div_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  function automatic bit legal(int p, int a, int b);
    return p >= 2 && b >= 1 && a < p && a <= b;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: count input clocks against the active ratio
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_p = 4; m_a = 1; m_b = 3; m_err = 0; started = 1;
    end else if (m_cnt == m_p * m_b + m_a - 1) begin
      m_cnt = 0;
      if (legal(int'(cfg_p), int'(cfg_a), int'(cfg_b))) begin
        m_p = int'(cfg_p); m_a = int'(cfg_a); m_b = int'(cfg_b);
      end else begin
        m_err = 1;
      end
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk({phase, " R2/R3 div_out"}, div_out, m_cnt == m_p * m_b + m_a - 1);
      chk({phase, " R4 mod_ctl"}, mod_ctl, m_cnt < (m_p + 1) * m_a);
      chk({phase, " R6 cfg_err"}, cfg_err, m_err);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int a, input int b, input string tag);
    @(negedge clk);
    #1;
    cfg_p = PW'(p); cfg_a = PW'(a); cfg_b = BW'(b);
    phase = tag;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset div_out", div_out, 1'b0);
    chk("R1 reset mod_ctl", mod_ctl, 1'b1);
    chk("R1 reset cfg_err", cfg_err, 1'b0);
    phase = "R2 defaults";
    run(40);
    set_cfg(5, 2, 4, "R5 mid-cycle change");
    run(70);
    set_cfg(3, 0, 5, "R8 zero swallow");
    run(50);
    set_cfg(3, 2, 2, "R9 full swallow");
    run(40);
    set_cfg(2, 1, 1, "R2 short ratio");
    run(20);
    set_cfg(3, 3, 5, "R6 swallow not below P");
    run(40);
    chk("R6 flag after rejected ratio", cfg_err, 1'b1);
    set_cfg(6, 1, 2, "R7 valid after error");
    run(50);
    chk("R7 flag still set", cfg_err, 1'b1);
    set_cfg(8, 5, 3, "R6 B below A");
    run(60);
    set_cfg(15, 14, 63, "R2 largest ratio");
    run(2000);
    set_cfg(7, 3, 9, "R10 reset mid-cycle");
    run(30);
    #1 rst = 1'b1;
    run(2);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 flag cleared", cfg_err, 1'b0);
    chk("R10 restart in P+1 mode", mod_ctl, 1'b1);
    run(200);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: all requirements, got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule